// File: doc/BRIEF.md
# Error-Tagged Receive FIFO with Line Status

This block sits between a serial receiver and the host side of a UART. Each character the receiver completes is stored together with three error tags: parity error, framing error and break. The host sees the oldest stored character on `head_char` at all times. It removes that character with a one-cycle `rd_en` pulse.

Beside the data, the block presents a six-bit line-status word. The word shows whether data is waiting and whether an overrun has occurred. It carries the three error tags of the oldest character, so software reads the status first and then pops the character it describes. It also shows whether any stored character, not only the head, carries an error tag. To know when that last flag may drop, the block counts how many stored entries are tagged.

Every strobe takes effect at the rising clock edge where it is sampled high. Both outputs show the new state from that edge onward, and no input reaches an output without passing a flop. Storage uses a memory with a synchronous write port and a registered read port, so it can map onto block RAM.

Top module: `rxq_err_fifo`

## Requirements
- R1: The FIFO holds DEPTH characters (default 64). Exactly DEPTH pushes into an empty FIFO are all kept and come out later in push order.
- R2: `head_char` always shows the oldest stored character and stays unchanged until it is popped. A `rd_en` pulse removes it, and from the next edge the following character is shown.
- R3: Status bit 2 (parity), bit 3 (framing) and bit 4 (break) equal the tags of the head entry. The tags are written on `wr_flags`, where bit 0 is parity, bit 1 is framing and bit 2 is break.
- R4: Status bit 5 is 1 while at least one stored entry has any tag set. It returns to 0 on the edge that pops the last tagged entry.
- R5: Status bit 0 is 1 exactly when at least one character is stored.
- R6: A push while the FIFO is full is discarded, and the stored contents are unchanged. The same edge sets status bit 1 (overrun). This holds even when a pop happens in that same cycle.
- R7: A `stat_rd` pulse clears status bit 1. If an overrun push arrives in the same cycle, the bit stays set.
- R8: A push and a pop in the same cycle on a non-empty, non-full FIFO leave the occupancy unchanged. They keep the tagged-entry count exact, whichever of the two entries is tagged.
- R9: When the FIFO is empty, status bits 2 to 4 and `head_char` read 0. A `rd_en` pulse while empty has no effect.
- R10: After reset the FIFO is empty and the whole status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver push strobe |
| wr_char | input | DATA_W | Received character |
| wr_flags | input | 3 | Tags of the pushed character: [0] parity, [1] framing, [2] break |
| rd_en | input | 1 | Host pop strobe |
| stat_rd | input | 1 | Host status-read strobe; clears the overrun bit |
| head_char | output | DATA_W | Oldest stored character, 0 when empty |
| status | output | 6 | [0] data waiting, [1] overrun, [2] head parity, [3] head framing, [4] head break, [5] tag anywhere |

## Verification
The bench targets these corner cases:

- **Push into an empty FIFO.** The push is followed at once by reads, which exercises the read-during-write bypass. A design without the bypass would show stale memory on `head_char`.
- **Push and pop in one cycle with one item stored.** This is the same bypass path, and it fails the same way.
- **Mixed-tag sequences.** A tagged entry sits behind clean ones, and clean entries sit behind a tagged one. A design that kept a sticky flag, or that decremented its tag count on the wrong entry, would drop or hold bit 5 at the wrong time.
- **Pushes against a full FIFO, with and without a pop in the same cycle.** A design that overwrote storage would emit the discarded character later.
- **A status read in the same cycle as an overrun.** A design that let the clear win would lose the overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  localparam int ST_AVAIL = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_ANY   = 5;
  localparam int ST_W     = 6;
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  // Simple dual-port storage: synchronous write, registered read (old data on collision).
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          stat_rd,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr_nxt,
  output logic [CW-1:0] cnt,
  output logic          ovr
);
  logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ovr_q, full, empty, ovr_evt;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign ovr_evt = push && full;

  always_comb begin
    wr_nxt = push_ok ? wrap_inc(wr_q) : wr_q;
    rd_nxt = pop_ok  ? wrap_inc(rd_q) : rd_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  assign waddr     = wr_q;
  assign raddr_nxt = rd_nxt;
  assign cnt       = cnt_q;
  assign ovr       = ovr_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R1
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovr_q); // R6
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt_q == CW'(DEPTH))); // R6
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(push && full)) |=> !ovr_q); // R7
  AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] fifo_cnt,
  output logic          any_err
);
  logic [CW-1:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   err_q <= err_q + 1'b1;
        2'b01:   err_q <= err_q - 1'b1;
        default: err_q <= err_q;
      endcase
    end
  end

  assign any_err = (err_q != '0);

  AST_ERR_WITHIN_FILL: assert property (@(posedge clk) disable iff (rst)
    err_q <= fifo_cnt); // R4
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_char,
  input  logic [2:0]        wr_flags,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] head_char,
  output logic [ST_W-1:0]   status
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + FLAG_W;

  logic          push_ok, pop_ok, ovr, any_err, nonempty;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] cnt;
  logic [EW-1:0] wdata, ram_q, byp_data_q, head_ent;
  logic          byp_q;
  rxq_flags_t    head_fl;

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push(wr_en), .pop(rd_en), .stat_rd(stat_rd),
    .push_ok(push_ok), .pop_ok(pop_ok), .waddr(waddr), .raddr_nxt(raddr),
    .cnt(cnt), .ovr(ovr)
  );

  assign wdata = {wr_flags, wr_char};

  rxq_ram #(.WIDTH(EW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(push_ok), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(ram_q)
  );

  // Read-during-write forwarding: the RAM returns old data on an address collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q      <= 1'b0;
      byp_data_q <= '0;
    end else begin
      byp_q      <= push_ok && (waddr == raddr);
      byp_data_q <= wdata;
    end
  end

  assign head_ent = byp_q ? byp_data_q : ram_q;
  assign head_fl  = rxq_flags_t'(head_ent[EW-1 -: FLAG_W]);
  assign nonempty = (cnt != '0);

  rxq_errtrack #(.CW(CW)) u_err (
    .clk(clk), .rst(rst),
    .inc(push_ok && (wr_flags != '0)),
    .dec(pop_ok && (head_fl != '0)),
    .fifo_cnt(cnt), .any_err(any_err)
  );

  always_comb begin
    status           = '0;
    status[ST_AVAIL] = nonempty;
    status[ST_OVR]   = ovr;
    status[ST_PAR]   = nonempty && head_fl.par;
    status[ST_FRM]   = nonempty && head_fl.frm;
    status[ST_BRK]   = nonempty && head_fl.brk;
    status[ST_ANY]   = any_err;
    head_char        = nonempty ? head_ent[DATA_W-1:0] : '0;
  end

  AST_ANY_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    status[ST_ANY] |-> status[ST_AVAIL]); // R4
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (nonempty && !rd_en) |=> $stable(head_char)); // R2
endmodule

// File: tb/rxq_err_fifo_bench.sv
module rxq_err_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int DW         = 8;
  localparam int WDOG       = 20000;

  typedef struct packed { logic [2:0] fl; logic [DW-1:0] ch; } ent_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en, stat_rd;
  logic [DW-1:0] wr_char;
  logic [2:0]    wr_flags;
  logic [DW-1:0] head_char;
  logic [5:0]    status;

  ent_t  exp_q[$];
  logic  m_ovr;
  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R10";
  bit    done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_rxq_err_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_flags(wr_flags),
    .rd_en(rd_en), .stat_rd(stat_rd), .head_char(head_char), .status(status)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares the outputs against the scoreboard head and status model.
  task automatic monitor();
    logic [5:0] e;
    bit any = 1'b0;
    foreach (exp_q[i]) if (exp_q[i].fl != 3'b000) any = 1'b1;
    e = '0;
    e[0] = (exp_q.size() > 0);
    e[1] = m_ovr;
    if (exp_q.size() > 0) e[4:2] = exp_q[0].fl;
    e[5] = any;
    chk(cur_tag, "status", int'(status), int'(e));
    chk(cur_tag, "head_char", int'(head_char), (exp_q.size() > 0) ? int'(exp_q[0].ch) : 0);
  endtask

  // Driver: one clock of stimulus; the scoreboard is updated to the post-edge state.
  task automatic step(bit push, logic [DW-1:0] ch, logic [2:0] fl, bit pop, bit srd);
    bit full;
    @(negedge clk);
    monitor();
    wr_en = push; wr_char = ch; wr_flags = fl; rd_en = pop; stat_rd = srd;
    full = (exp_q.size() == DEPTH);
    if (pop && exp_q.size() > 0) void'(exp_q.pop_front());
    if (push) begin
      if (full) m_ovr = 1'b1;
      else exp_q.push_back('{fl: fl, ch: ch});
    end
    if (srd && !(push && full)) m_ovr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 3'b000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_ovr = 1'b0;
    rst = 1'b1; wr_en = 0; rd_en = 0; stat_rd = 0; wr_char = '0; wr_flags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    cur_tag = "R10"; idle(); idle();

    // R2 / R5: clean characters in order, immediate reads after a push into empty
    cur_tag = "R5";
    step(1, 8'h41, 3'b000, 0, 0);
    idle();
    cur_tag = "R2";
    step(1, 8'h42, 3'b000, 0, 0);
    step(1, 8'h43, 3'b000, 0, 0);
    step(0, '0, 3'b000, 1, 0);
    step(0, '0, 3'b000, 1, 0);
    step(0, '0, 3'b000, 1, 0);
    idle();

    // R3: each tag on its own at the head
    cur_tag = "R3";
    step(1, 8'h10, 3'b001, 0, 0);
    step(1, 8'h11, 3'b010, 0, 0);
    step(1, 8'h12, 3'b100, 0, 0);
    step(1, 8'h13, 3'b000, 0, 0);
    step(1, 8'h14, 3'b111, 0, 0);
    for (int i = 0; i < 5; i++) step(0, '0, 3'b000, 1, 0);
    idle();

    // R4: a tagged entry behind clean ones; the anywhere bit drops only when it leaves
    cur_tag = "R4";
    step(1, 8'h20, 3'b000, 0, 0);
    step(1, 8'h21, 3'b000, 0, 0);
    step(1, 8'h22, 3'b010, 0, 0);
    step(1, 8'h23, 3'b000, 0, 0);
    step(1, 8'h24, 3'b100, 0, 0);
    for (int i = 0; i < 6; i++) step(0, '0, 3'b000, 1, 0);

    // R8: simultaneous push and pop with every tag mix, including one stored entry
    cur_tag = "R8";
    step(1, 8'h30, 3'b001, 0, 0);
    step(1, 8'h31, 3'b000, 1, 0);
    step(1, 8'h32, 3'b010, 1, 0);
    step(1, 8'h33, 3'b100, 1, 0);
    step(1, 8'h34, 3'b000, 1, 0);
    step(1, 8'h35, 3'b000, 0, 0);
    step(1, 8'h36, 3'b001, 1, 0);
    step(1, 8'h37, 3'b000, 1, 0);
    step(0, '0, 3'b000, 1, 0);
    step(0, '0, 3'b000, 1, 0);
    idle();

    // R1: fill to capacity with a tag on the last entry
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++)
      step(1, DW'(8'h80 + i), (i == DEPTH - 1) ? 3'b010 : 3'b000, 0, 0);
    idle();

    // R6: pushes while full are discarded, alone and alongside a pop
    cur_tag = "R6";
    step(1, 8'hEE, 3'b111, 0, 0);
    idle();
    step(1, 8'hED, 3'b000, 1, 0);
    idle();

    // R7: a status read clears overrun; one colliding with an overrun keeps it set
    cur_tag = "R7";
    step(0, '0, 3'b000, 0, 1);
    idle();
    step(1, 8'h05, 3'b000, 0, 0);
    step(1, 8'hEC, 3'b001, 0, 1);
    idle();
    step(0, '0, 3'b000, 0, 1);
    idle();

    // R1: drain everything; the discarded characters must never appear
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++) step(0, '0, 3'b000, 1, 0);

    // R9: empty FIFO, pops ignored, head tags read 0
    cur_tag = "R9";
    idle();
    step(0, '0, 3'b000, 1, 0);
    step(0, '0, 3'b000, 1, 0);
    step(1, 8'h55, 3'b100, 0, 0);
    step(0, '0, 3'b000, 1, 0);
    idle();
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule